// File: doc/BRIEF.md
# Touch-Sense Duty Counter

This peripheral times how long a capacitive touch pad takes to charge. It sits on a narrow 4-bit microcontroller data bus. Software first sets a 12-bit start value and then writes the start register. The counter then counts up by one on every clock. It stops on one of two events. The first is a wrap from all ones to zero. The second is a rising edge on the external overcharge comparator input. Software then reads the elapsed count back one nibble at a time. Each of the two events raises its own flag, and each flag can be routed to a single interrupt request line.

The 12-bit value sits behind three consecutive nibble addresses. A write to these addresses goes to a reload latch. A read from them returns the live count. A write to the start register reloads the counter from the latch, starts it and clears both flags in one step. The comparator input is asynchronous, so the block synchronizes it before use.

Top module: `touch_duty_ctr`

## Requirements
- R1: After reset, both interrupt enables and both flags read 0, `irq_o` is low and the counter does not advance.
- R2: Addresses 0x213, 0x214 and 0x215 read count bits [3:0], [7:4] and [11:8] respectively, so count = nib(0x215)*256 + nib(0x214)*16 + nib(0x213).
- R3: A write to 0x213, 0x214 or 0x215 changes only the matching nibble of the reload latch. The live count is not disturbed.
- R4: A write of any value to the start register (0x212) loads the counter from the reload latch at that clock edge. The counter then adds one on every following clock.
- R5: When the running count is 0xFFF, the next clock sets it to 0x000, stops it and sets the overflow flag (flag register 0x01F bit 3) at that same edge.
- R6: `ocharge_i` passes through two synchronizer flops. Take the clock edges after the input first rises as e1, e2 and e3. At e3 the overcharge flag (0x01F bit 2) is set and the counter holds, so the count keeps the value it had after e2.
- R7: A start-register write clears both the overflow and the overcharge flag.
- R8: Writing 0 to bit 3 or bit 2 of 0x01F clears that flag, and writing 1 leaves it unchanged. If a hardware set and a clear land in the same cycle, the flag ends up set.
- R9: Register 0x01E holds the overflow interrupt enable in bit 3 and the overcharge interrupt enable in bit 2. Both bits can be written and read back.
- R10: `irq_o` is high exactly when (overflow flag AND its enable) OR (overcharge flag AND its enable).
- R11: Bits 1 and 0 of 0x01E and 0x01F read 0. The start register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 12 | Register address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 4 | Write data nibble |
| bus_rdata_o | output | 4 | Read data nibble, combinational from the address |
| ocharge_i | input | 1 | Asynchronous overcharge comparator input |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that each bus cycle performs at most one write, so a start write and a latch write never share a cycle. They also assume that `ocharge_i` stays stable long enough for the two synchronizer flops to see every level. The bench drives the bus and the comparator input only on falling clock edges. It holds each comparator level for at least three cycles and never starts the counter in the same cycle as an overcharge edge. It reads the count nibbles within one low clock phase, so all three nibbles describe the same count.

// File: rtl/tds_pkg.sv
package tds_pkg;
   localparam int unsigned NIB_W = 4;
   typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/tds_sync_edge.sv
module tds_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tds_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         last_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], async_i};
         last_q  <= shift_q[STAGES-1];
      end
   end

   assign rise_o = shift_q[STAGES-1] & ~last_q;

   // R6: a detected edge is a single-cycle pulse
   p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tds_counter.sv
module tds_counter
   import tds_pkg::*;
#(
   parameter int unsigned CNT_W = 12,
   localparam int unsigned NIBS = CNT_W / NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic [NIBS-1:0]  nib_we_i,
   input  nib_t             nib_d_i,
   output logic [CNT_W-1:0] count_o,
   output logic             running_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if ((CNT_W % NIB_W) != 0 || CNT_W < NIB_W) begin : g_bad_width
      $error("tds_counter: CNT_W must be a positive multiple of the nibble width");
   end

   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   for (genvar g = 0; g < NIBS; g++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           latch_q[g*NIB_W +: NIB_W] <= '0;
         else if (nib_we_i[g]) latch_q[g*NIB_W +: NIB_W] <= nib_d_i;
      end
   end

   assign wrap_o = run_q && !load_i && !stop_i && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= latch_q;
         run_q <= 1'b1;
      end else if (stop_i) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_MAX) run_q <= 1'b0;
      end
   end

   assign count_o   = cnt_q;
   assign running_o = run_q;

   // R4: a start loads the latch and runs
   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(latch_q)) && run_q);
   // R4: one step per clock while running
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !load_i && !stop_i && cnt_q != CNT_MAX)
      |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
   // R5: wrap lands on zero and stops
   p_wrap_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0) && !run_q);
   // R3: latch writes never move an idle count
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/touch_duty_ctr.sv
module touch_duty_ctr
   import tds_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h01E,
   parameter logic [ADDR_W-1:0] FLAG_ADDR  = 'h01F,
   parameter logic [ADDR_W-1:0] START_ADDR = 'h212,
   parameter logic [ADDR_W-1:0] CNT_BASE   = 'h213,
   parameter int unsigned OVF_BIT = 3,
   parameter int unsigned OCP_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [3:0]        bus_wdata_i,
   output logic [3:0]        bus_rdata_o,
   input  logic              ocharge_i,
   output logic              irq_o
);
   localparam int unsigned NIBS = CNT_W / NIB_W;

   if (OVF_BIT == OCP_BIT || OVF_BIT >= NIB_W || OCP_BIT >= NIB_W) begin : g_bad_bits
      $error("touch_duty_ctr: flag bit positions must be distinct and inside a nibble");
   end

   logic             start_wr, ctrl_wr, flag_wr;
   logic [NIBS-1:0]  nib_we;
   logic [CNT_W-1:0] count;
   logic             running, wrap, oc_rise;
   logic             ie_ovf_q, ie_ocp_q;
   logic             fl_ovf_q, fl_ocp_q;

   assign start_wr = bus_we_i && (bus_addr_i == START_ADDR);
   assign ctrl_wr  = bus_we_i && (bus_addr_i == CTRL_ADDR);
   assign flag_wr  = bus_we_i && (bus_addr_i == FLAG_ADDR);

   for (genvar g = 0; g < NIBS; g++) begin : g_nib_dec
      assign nib_we[g] = bus_we_i && (bus_addr_i == CNT_BASE + ADDR_W'(g));
   end

   tds_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ocharge_i),
      .rise_o  (oc_rise)
   );

   tds_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_wr),
      .stop_i    (oc_rise),
      .nib_we_i  (nib_we),
      .nib_d_i   (nib_t'(bus_wdata_i)),
      .count_o   (count),
      .running_o (running),
      .wrap_o    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_ovf_q <= 1'b0;
         ie_ocp_q <= 1'b0;
      end else if (ctrl_wr) begin
         ie_ovf_q <= bus_wdata_i[OVF_BIT];
         ie_ocp_q <= bus_wdata_i[OCP_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_ovf_q <= 1'b0;
         fl_ocp_q <= 1'b0;
      end else begin
         if (wrap)          fl_ovf_q <= 1'b1;
         else if (start_wr) fl_ovf_q <= 1'b0;
         else if (flag_wr)  fl_ovf_q <= fl_ovf_q & bus_wdata_i[OVF_BIT];

         if (oc_rise)       fl_ocp_q <= 1'b1;
         else if (start_wr) fl_ocp_q <= 1'b0;
         else if (flag_wr)  fl_ocp_q <= fl_ocp_q & bus_wdata_i[OCP_BIT];
      end
   end

   assign irq_o = (fl_ovf_q & ie_ovf_q) | (fl_ocp_q & ie_ocp_q);

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == CTRL_ADDR) begin
         bus_rdata_o[OVF_BIT] = ie_ovf_q;
         bus_rdata_o[OCP_BIT] = ie_ocp_q;
      end else if (bus_addr_i == FLAG_ADDR) begin
         bus_rdata_o[OVF_BIT] = fl_ovf_q;
         bus_rdata_o[OCP_BIT] = fl_ocp_q;
      end
      for (int g = 0; g < int'(NIBS); g++) begin
         if (bus_addr_i == CNT_BASE + ADDR_W'(g))
            bus_rdata_o = count[g*NIB_W +: NIB_W];
      end
   end

   // R5: a wrap raises the overflow flag
   p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> fl_ovf_q);
   // R6: an overcharge edge raises its flag and halts the count
   p_ocp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_rise && !start_wr) |=> fl_ocp_q && !running);
   // R7: a start clears both flags when no event coincides
   p_start_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !wrap && !oc_rise) |=> !fl_ovf_q && !fl_ocp_q);
   // R8: without a set, start or flag write the overflow flag holds
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !start_wr && !flag_wr) |=> $stable(fl_ovf_q));
   // R10: no request while both enables are off
   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_ovf_q && !ie_ocp_q) |-> !irq_o);
endmodule

// File: tb/test_touch_duty_ctr.sv
`timescale 1ns/1ps
module test_touch_duty_ctr;
   localparam logic [11:0] A_CTRL  = 12'h01E;
   localparam logic [11:0] A_FLAG  = 12'h01F;
   localparam logic [11:0] A_START = 12'h212;
   localparam logic [11:0] A_C0    = 12'h213;
   localparam logic [11:0] A_C1    = 12'h214;
   localparam logic [11:0] A_C2    = 12'h215;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [3:0]  wdata = '0;
   logic [3:0]  rdata;
   logic        ocharge = 1'b0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   touch_duty_ctr i_touch_duty_ctr (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ocharge_i(ocharge), .irq_o(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [3:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [3:0] d);
      addr = a;
      #0.1;
      d = rdata;
   endtask

   task automatic rd_cnt(output int v);
      logic [3:0] l, m, h;
      rd(A_C0, l); rd(A_C1, m); rd(A_C2, h);
      v = int'(h) * 256 + int'(m) * 16 + int'(l);
   endtask

   task automatic set_latch(input int v);
      wr(A_C0, 4'(v)); wr(A_C1, 4'(v >> 4)); wr(A_C2, 4'(v >> 8));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [3:0] r;
      int c;
      idle(3);
      // R1: reset state
      rd(A_CTRL, r); chk("R1 ctrl", r, 0);
      rd(A_FLAG, r); chk("R1 flag", r, 0);
      chk("R1 irq", irq, 0);
      rd_cnt(c); chk("R1 count", c, 0);
      rst_n = 1'b1;
      idle(5);
      rd_cnt(c); chk("R1 idle count", c, 0);

      // R2: nibble order and composition
      set_latch('hABC);
      wr(A_START, 4'h0);
      rd(A_C0, r); chk("R2 low nibble", r, 'hC);
      rd(A_C1, r); chk("R2 mid nibble", r, 'hB);
      rd(A_C2, r); chk("R2 high nibble", r, 'hA);
      idle(7);
      rd_cnt(c); chk("R4 counting", c, 'hAC3);

      // R3: latch write does not disturb the live count
      set_latch('h200);
      wr(A_START, 4'h5);
      idle(4);
      wr(A_C0, 4'hA);
      rd_cnt(c); chk("R3 live count", c, 'h205);
      wr(A_START, 4'h0);
      rd_cnt(c); chk("R3 latch nibble", c, 'h20A);

      // R5 sweep: wrap timing for every start value in the top 256
      for (int L = 'hF00; L <= 'hFFF; L++) begin
         set_latch(L);
         wr(A_START, 4'h0);
         idle('hFFF - L);
         rd_cnt(c); chk("R5 pre-wrap count", c, 'hFFF);
         rd(A_FLAG, r); chk("R5 pre-wrap flag", r, 0);
         idle(1);
         rd_cnt(c); chk("R5 wrapped count", c, 0);
         rd(A_FLAG, r); chk("R5 flag set", r, 'h8);
         idle(2);
         rd_cnt(c); chk("R5 stays stopped", c, 0);
      end
      // R5: full run from zero
      set_latch(0);
      wr(A_START, 4'h0);
      idle('hFFF);
      rd(A_FLAG, r); chk("R5 full-run pre flag", r, 0);
      idle(1);
      rd(A_FLAG, r); chk("R5 full-run flag", r, 'h8);

      // R7: start clears the overflow flag
      set_latch('h100);
      wr(A_START, 4'h0);
      rd(A_FLAG, r); chk("R7 start clears", r, 0);

      // R6: overcharge edge timing
      idle(5);
      rd_cnt(c); chk("R4 pre-overcharge", c, 'h105);
      ocharge = 1'b1;
      idle(2);
      rd_cnt(c); chk("R6 after e2 count", c, 'h107);
      rd(A_FLAG, r); chk("R6 after e2 flag", r, 0);
      idle(1);
      rd_cnt(c); chk("R6 held count", c, 'h107);
      rd(A_FLAG, r); chk("R6 flag set", r, 'h4);
      idle(10);
      rd_cnt(c); chk("R6 still held", c, 'h107);
      ocharge = 1'b0;
      idle(4);

      // R10: enables gate the request
      chk("R10 irq no enable", irq, 0);
      wr(A_CTRL, 4'h8);
      chk("R10 irq wrong enable", irq, 0);
      wr(A_CTRL, 4'h4);
      chk("R10 irq ocp enabled", irq, 1);
      // R9 and R11: enable read back, unused bits zero
      wr(A_CTRL, 4'hF);
      rd(A_CTRL, r); chk("R9 ctrl readback", r, 'hC);

      // R8: write 1 keeps, write 0 clears
      wr(A_FLAG, 4'hF);
      rd(A_FLAG, r); chk("R8 write ones keeps", r, 'h4);
      wr(A_FLAG, 4'h0);
      rd(A_FLAG, r); chk("R8 write zero clears", r, 0);
      chk("R10 irq after clear", irq, 0);
      wr(A_FLAG, 4'hC);
      rd(A_FLAG, r); chk("R8 ones do not set", r, 0);

      // R7: start clears both flags together
      set_latch('hFFE);
      wr(A_START, 4'h0);
      idle(2);
      chk("R10 irq ovf", irq, 1);
      ocharge = 1'b1; idle(4); ocharge = 1'b0; idle(4);
      rd(A_FLAG, r); chk("R7 both set", r, 'hC);
      wr(A_START, 4'h0);
      rd(A_FLAG, r); chk("R7 both cleared", r, 0);
      chk("R10 irq cleared", irq, 0);

      // R8: hardware set wins over same-cycle clear
      set_latch('hFFF);
      wr(A_START, 4'h0);
      wr(A_FLAG, 4'h0);
      rd(A_FLAG, r); chk("R8 set wins", r, 'h8);
      wr(A_CTRL, 4'h0);
      rd(A_CTRL, r); chk("R9 ctrl cleared", r, 0);

      // R11: non-register reads
      rd(A_START, r); chk("R11 start reads zero", r, 0);
      rd(12'h000, r); chk("R11 unmapped zero", r, 0);
      rd(12'h216, r); chk("R11 past counter zero", r, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule